// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This unit holds the program counter of a small controller whose program space is 8192 words of 16 bits. Every cycle it presents a fetch address. It then picks the address for the following cycle from one of seven sources: the next sequential word, an absolute jump or call target, a return address, a new low byte written into the counter, a skip over the prefetched word, an interrupt vector, or the reset vector.

Fetch runs one word ahead of execution. Any change of flow therefore discards the word already fetched. The unit raises `flush` for the cycle in which that stale word sits in the execute slot, so the decoder runs it as a no-operation. Control strobes that arrive during a flushed cycle have no effect.

Interrupts are arbitrated only at real instruction boundaries. When an interrupt is taken, the unit issues a push request that carries the resume address, and it clears the master interrupt enable.

All pins are plain per-cycle control and status. The fetch address is a free-running stream with no back-pressure: the consumer must accept one address every cycle, and a stalled consumer has no means to hold it.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_addr` is 0x0000, `flush` is 1, `gie` is 0, `push_req` is 0 and `irq_ack` is 0.
- R2: In a cycle with `flush` low, no strobe and no interrupt taken, the next `fetch_addr` is the current value plus one, wrapping from 0x1FFF to 0x0000, and the next `flush` is 0.
- R3: In a cycle with `flush` high, every strobe (`jmp_stb`, `ret_stb`, `ret_int`, `pcl_wr`, `skip_stb`, `ie_wr`) is ignored. The next `fetch_addr` is the current value plus one and the next `flush` is 0.
- R4: A jump or call strobe in a cycle with `flush` low loads `jmp_addr` into the counter, and the next `flush` is 1.
- R5: A return strobe in a cycle with `flush` low loads `ret_addr`, and the next `flush` is 1. If `ret_int` is also high, `gie` becomes 1.
- R6: A write of the low counter byte in a cycle with `flush` low loads `{fetch_addr[12:8], pcl_data}`, which keeps the current 256-word page, and the next `flush` is 1.
- R7: A taken skip in a cycle with `flush` low loads the current `fetch_addr` plus one, and the next `flush` is 1.
- R8: When several strobes are high together, return wins over jump, jump wins over the low-byte write, and the low-byte write wins over skip.
- R9: The interrupt sources map to vectors as follows: `irq_req[0]` goes to 0x0004, `irq_req[1]` to 0x0008 and `irq_req[2]` to 0x000C. The lowest-indexed eligible source wins, and `irq_ack` is one-hot on that source.
- R10: An interrupt is taken only in a cycle where all of these hold: `flush` is low, `gie` is 1, `stack_full` is 0, and some `irq_req & irq_en` bit is set. In any other cycle, requests have no effect.
- R11: On interrupt entry, `push_req` is 1 and `push_addr` is the address that would have executed next: the strobe target if a strobe is active, otherwise the current `fetch_addr`. The next `fetch_addr` is the vector, the next `flush` is 1, and the next `gie` is 0.
- R12: `ie_wr` in a cycle with `flush` low loads `ie_val` into `gie`. Interrupt entry in the same cycle overrides it and leaves `gie` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_stb | input | 1 | Jump or call executes |
| jmp_addr | input | 13 | Jump or call target |
| ret_stb | input | 1 | Return executes |
| ret_addr | input | 13 | Address popped from the stack |
| ret_int | input | 1 | Return is from an interrupt; re-enables interrupts |
| pcl_wr | input | 1 | Write to the counter low byte |
| pcl_data | input | 8 | Value written to the low byte |
| skip_stb | input | 1 | Conditional skip is satisfied |
| irq_req | input | 3 | Interrupt requests, index 0 highest priority |
| irq_en | input | 3 | Per-source interrupt enables |
| ie_wr | input | 1 | Write of the master interrupt enable |
| ie_val | input | 1 | Value for the master interrupt enable |
| stack_full | input | 1 | Return stack has no free entry |
| fetch_addr | output | 13 | Address fetched this cycle |
| flush | output | 1 | Word in the execute slot is a dummy no-operation |
| gie | output | 1 | Master interrupt enable |
| push_req | output | 1 | Interrupt entry: push `push_addr` |
| push_addr | output | 13 | Resume address to push |
| irq_ack | output | 3 | One-hot source taken this cycle |

## Verification
The bench builds the unit with its default parameters: a 13-bit counter, 8-bit pages, three interrupt sources, and vectors starting at 4 with a stride of 4. With these values the bench reaches the top of the address space with a single jump to 0x1FFF, and so checks the wrap to zero. Three sources are also enough to check each vector, the priority among sources with several requests pending, and a low-byte write that keeps a nonzero page. The scoreboard model checks the resume address both for plain flow and for an interrupt that coincides with a jump or a skip.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Selected change-of-flow source for the instruction in the execute slot
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_RET  = 3'd1,
    FLOW_JMP  = 3'd2,
    FLOW_PCL  = 3'd3,
    FLOW_SKIP = 3'd4
  } flow_e;

endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int PAGE_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic              ret_stb,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              jmp_stb,
  input  logic [PC_W-1:0]   jmp_addr,
  input  logic              pcl_wr,
  input  logic [PAGE_W-1:0] pcl_data,
  input  logic              skip_stb,
  output flow_e             flow,
  output logic              redirect,
  output logic [PC_W-1:0]   target
);

  localparam int HI_W = PC_W - PAGE_W;

  logic [HI_W-1:0] page;
  assign page = pc[PC_W-1:PAGE_W];

  // Fixed priority: return, jump/call, low-byte write, skip
  always_comb begin
    flow   = FLOW_SEQ;
    target = pc;
    if (ret_stb) begin
      flow   = FLOW_RET;
      target = ret_addr;
    end else if (jmp_stb) begin
      flow   = FLOW_JMP;
      target = jmp_addr;
    end else if (pcl_wr) begin
      flow   = FLOW_PCL;
      target = {page, pcl_data};
    end else if (skip_stb) begin
      flow   = FLOW_SKIP;
      target = pc + PC_W'(1);
    end
  end

  assign redirect = (flow != FLOW_SEQ);

endmodule

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
  parameter int PC_W       = 13,
  parameter int N_IRQ      = 3,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic [N_IRQ-1:0] req,
  input  logic [N_IRQ-1:0] en,
  input  logic             allow,
  output logic             take,
  output logic [N_IRQ-1:0] ack,
  output logic [PC_W-1:0]  vector
);

  logic [PC_W-1:0]  vec_tab [N_IRQ];
  logic [N_IRQ-1:0] pend;
  logic             found;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
    assign vec_tab[g] = PC_W'(VEC_BASE + g * VEC_STRIDE);
  end

  assign pend = req & en;

  // Lowest index wins
  always_comb begin
    found  = 1'b0;
    ack    = '0;
    vector = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (allow && pend[i] && !found) begin
        found  = 1'b1;
        ack[i] = 1'b1;
        vector = vec_tab[i];
      end
    end
  end

  assign take = found;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int PAGE_W     = 8,
  parameter int N_IRQ      = 3,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_stb,
  input  logic [PC_W-1:0]   jmp_addr,
  input  logic              ret_stb,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              ret_int,
  input  logic              pcl_wr,
  input  logic [PAGE_W-1:0] pcl_data,
  input  logic              skip_stb,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              ie_wr,
  input  logic              ie_val,
  input  logic              stack_full,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              flush,
  output logic              gie,
  output logic              push_req,
  output logic [PC_W-1:0]   push_addr,
  output logic [N_IRQ-1:0]  irq_ack
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            dummy_q, dummy_d;
  logic            gie_q, gie_d;

  flow_e           flow;
  logic            redirect;
  logic [PC_W-1:0] target;
  logic            live;
  logic            allow;
  logic            take;
  logic [PC_W-1:0] vector;

  assign live = !dummy_q;

  pcseq_target #(
    .PC_W   (PC_W),
    .PAGE_W (PAGE_W)
  ) u_target (
    .pc       (pc_q),
    .ret_stb  (ret_stb),
    .ret_addr (ret_addr),
    .jmp_stb  (jmp_stb),
    .jmp_addr (jmp_addr),
    .pcl_wr   (pcl_wr),
    .pcl_data (pcl_data),
    .skip_stb (skip_stb),
    .flow     (flow),
    .redirect (redirect),
    .target   (target)
  );

  assign allow = live && gie_q && !stack_full;

  pcseq_irq_arb #(
    .PC_W       (PC_W),
    .N_IRQ      (N_IRQ),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_arb (
    .req    (irq_req),
    .en     (irq_en),
    .allow  (allow),
    .take   (take),
    .ack    (irq_ack),
    .vector (vector)
  );

  // Next-state selection; a dummy slot only advances past the new target
  always_comb begin
    pc_d    = pc_q + PC_W'(1);
    dummy_d = 1'b0;
    gie_d   = gie_q;
    if (live) begin
      if (take) begin
        pc_d    = vector;
        dummy_d = 1'b1;
        gie_d   = 1'b0;
      end else begin
        if (redirect) begin
          pc_d    = target;
          dummy_d = 1'b1;
        end
        if (flow == FLOW_RET && ret_int) gie_d = 1'b1;
        else if (ie_wr)                  gie_d = ie_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      dummy_q <= 1'b1;
      gie_q   <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      dummy_q <= dummy_d;
      gie_q   <= gie_d;
    end
  end

  assign fetch_addr = pc_q;
  assign flush      = dummy_q;
  assign gie        = gie_q;
  assign push_req   = take;
  assign push_addr  = (live && redirect) ? target : pc_q;

  // R3
  dummy_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_q |=> (pc_q == PC_W'($past(pc_q) + 1)) && !dummy_q);

  // R2
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dummy_q && !push_req && !jmp_stb && !ret_stb && !pcl_wr && !skip_stb)
    |=> (pc_q == PC_W'($past(pc_q) + 1)) && !dummy_q);

  // R10
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_full || !gie_q || dummy_q) |-> !push_req);

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack) && (push_req == (irq_ack != '0)));

  // R11
  entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !gie_q && dummy_q);

  // R6
  pcl_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dummy_q && !push_req && pcl_wr && !ret_stb && !jmp_stb)
    |=> (pc_q[PC_W-1:PAGE_W] == $past(pc_q[PC_W-1:PAGE_W])) && dummy_q);

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        jmp_stb, ret_stb, ret_int, pcl_wr, skip_stb, ie_wr, ie_val, stack_full;
  logic [12:0] jmp_addr, ret_addr;
  logic [7:0]  pcl_data;
  logic [2:0]  irq_req, irq_en;
  logic [12:0] fetch_addr, push_addr;
  logic        flush, gie, push_req;
  logic [2:0]  irq_ack;

  always #4 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .jmp_stb(jmp_stb), .jmp_addr(jmp_addr),
    .ret_stb(ret_stb), .ret_addr(ret_addr), .ret_int(ret_int),
    .pcl_wr(pcl_wr), .pcl_data(pcl_data), .skip_stb(skip_stb),
    .irq_req(irq_req), .irq_en(irq_en), .ie_wr(ie_wr), .ie_val(ie_val),
    .stack_full(stack_full), .fetch_addr(fetch_addr), .flush(flush),
    .gie(gie), .push_req(push_req), .push_addr(push_addr), .irq_ack(irq_ack)
  );

  typedef struct {
    logic [12:0] fa;
    logic        fl;
    logic        g;
    logic        pr;
    logic [12:0] pa;
    logic [2:0]  ack;
    string       st_tag;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  logic [12:0] m_pc   = '0;
  logic        m_dum  = 1'b1;
  logic        m_gie  = 1'b0;
  string       prev_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge; drives one cycle and queues its expectation
  task automatic step(string tag, logic j = 0, logic [12:0] jt = 0, logic r = 0,
                      logic [12:0] rt = 0, logic ri = 0, logic pw = 0,
                      logic [7:0] pd = 0, logic sk = 0, logic [2:0] rq = 0,
                      logic [2:0] en = 0, logic sf = 0, logic iw = 0, logic iv = 0);
    exp_t        e;
    logic        live, redir, take;
    logic [12:0] tgt;
    logic [2:0]  pend, ack;
    logic [12:0] vec;
    jmp_stb = j;  jmp_addr = jt; ret_stb = r; ret_addr = rt; ret_int = ri;
    pcl_wr = pw;  pcl_data = pd; skip_stb = sk; irq_req = rq; irq_en = en;
    stack_full = sf; ie_wr = iw; ie_val = iv;
    live = !m_dum;
    tgt  = m_pc;
    if (r)       tgt = rt;
    else if (j)  tgt = jt;
    else if (pw) tgt = {m_pc[12:8], pd};
    else if (sk) tgt = m_pc + 13'd1;
    redir = live && (r || j || pw || sk);
    pend  = rq & en;
    take  = live && m_gie && !sf && (pend != 3'b000);
    ack   = 3'b000;
    vec   = '0;
    if (take) begin
      if (pend[0])      begin ack = 3'b001; vec = 13'h0004; end
      else if (pend[1]) begin ack = 3'b010; vec = 13'h0008; end
      else              begin ack = 3'b100; vec = 13'h000C; end
    end
    e.fa = m_pc; e.fl = m_dum; e.g = m_gie; e.pr = take;
    e.pa = redir ? tgt : m_pc; e.ack = ack; e.st_tag = prev_tag; e.tag = tag;
    sbq.push_back(e);
    if (!live) begin
      m_pc = m_pc + 13'd1; m_dum = 1'b0;
    end else if (take) begin
      m_pc = vec; m_dum = 1'b1; m_gie = 1'b0;
    end else begin
      if (redir) begin m_pc = tgt; m_dum = 1'b1; end
      else begin m_pc = m_pc + 13'd1; m_dum = 1'b0; end
      if (r && ri)  m_gie = 1'b1;
      else if (iw)  m_gie = iv;
    end
    prev_tag = tag;
    @(negedge clk);
  endtask

  // Monitor: compares outputs 2 ns after each falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(e.st_tag, "fetch_addr", int'(fetch_addr), int'(e.fa));
        chk(e.st_tag, "flush", int'(flush), int'(e.fl));
        chk(e.st_tag, "gie", int'(gie), int'(e.g));
        chk(e.tag, "push_req", int'(push_req), int'(e.pr));
        chk(e.tag, "irq_ack", int'(irq_ack), int'(e.ack));
        if (e.pr) chk(e.tag, "push_addr", int'(push_addr), int'(e.pa));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    jmp_stb = 0; ret_stb = 0; ret_int = 0; pcl_wr = 0; skip_stb = 0;
    ie_wr = 0; ie_val = 0; stack_full = 0; jmp_addr = '0; ret_addr = '0;
    pcl_data = '0; irq_req = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1: outputs while reset is held
    chk("R1", "fetch_addr", int'(fetch_addr), 0);
    chk("R1", "flush", int'(flush), 1);
    chk("R1", "gie", int'(gie), 0);
    chk("R1", "push_req", int'(push_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: strobes during the post-reset dummy slot are ignored
    step(.tag("R3"), .j(1), .jt(13'h0AB), .iw(1), .iv(1));
    step(.tag("R2"));
    step(.tag("R2"));
    step(.tag("R4"), .j(1), .jt(13'h155));
    step(.tag("R3"), .pw(1), .pd(8'h33), .sk(1), .r(1), .rt(13'h0999));
    step(.tag("R6"), .pw(1), .pd(8'h10));
    step(.tag("R2"));
    step(.tag("R7"), .sk(1));
    step(.tag("R2"));
    step(.tag("R5"), .r(1), .rt(13'h0777));
    step(.tag("R2"));
    step(.tag("R8"), .r(1), .rt(13'h0200), .j(1), .jt(13'h0300), .sk(1));
    step(.tag("R2"));
    step(.tag("R8"), .j(1), .jt(13'h0400), .pw(1), .pd(8'h55), .sk(1));
    step(.tag("R2"));
    step(.tag("R8"), .pw(1), .pd(8'hEE), .sk(1));
    step(.tag("R2"));
    // R10: gie low; R12: enable written
    step(.tag("R10"), .rq(3'b001), .en(3'b001), .iw(1), .iv(1));
    step(.tag("R10"), .rq(3'b111), .en(3'b111), .sf(1));
    step(.tag("R10"), .rq(3'b111), .en(3'b000));
    step(.tag("R9"), .rq(3'b111), .en(3'b111));
    step(.tag("R10"), .rq(3'b111), .en(3'b111));
    step(.tag("R10"), .rq(3'b010), .en(3'b010));
    step(.tag("R5"), .r(1), .rt(13'h04F2), .ri(1));
    step(.tag("R10"), .rq(3'b010), .en(3'b010));
    step(.tag("R9"), .rq(3'b110), .en(3'b110));
    step(.tag("R3"), .iw(1), .iv(1));
    step(.tag("R12"), .iw(1), .iv(1));
    step(.tag("R11"), .rq(3'b100), .en(3'b100), .j(1), .jt(13'h0ABC), .iw(1), .iv(1));
    step(.tag("R3"));
    step(.tag("R12"), .iw(1), .iv(1));
    step(.tag("R12"), .iw(1), .iv(0));
    step(.tag("R12"), .iw(1), .iv(1));
    step(.tag("R11"), .sk(1), .rq(3'b001), .en(3'b001));
    step(.tag("R3"));
    step(.tag("R12"), .iw(1), .iv(1));
    step(.tag("R2"), .j(1), .jt(13'h1FFF));
    step(.tag("R2"));
    step(.tag("R2"));
    step(.tag("R2"));
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule